// File: doc/BRIEF.md
# Toggle-Style Per-Channel Event Status Register

This block keeps a live status word for a multi-channel scan engine. Channels report events as pulses, each carrying a channel index and an event kind. Completion, seal-failure and underrun events flip their bit, so each new occurrence shows up as a change in the word. Software never has to clear a bit to rearm it. Bad-wakeup events work differently: each channel has its own bit for them, and that bit is set and stays set.

A separate published copy holds the word as it stood at the last notification. At the end of each scanline pass the engine pulses `publish`. If the live word differs from the published copy, the copy is refreshed. An interrupt pulse is raised when one of the changed bits is enabled in the interrupt mask. No acknowledge is needed, because the next notification depends only on a later difference. A bit that flips twice between two publishes produces no change and no notification, and the block accepts this. Software can overwrite the published copy and load the mask.

Top module: `tse_status`

## Requirements
- R1: A synchronous active-high reset clears the live status, the published copy, the interrupt mask and `irq_o`. The mask clear is observable: after reset, a changed word that is published raises no interrupt until the mask is written.
- R2: An event of kind 0 (done), 1 (bad seal) or 2 (underrun) on channel c inverts status bit `kind + 3*c`, and only that bit, at the next clock edge. Channel c occupies bits 3c..3c+2.
- R3: An event of kind 3 (bad wakeup) on channel c sets status bit `12 + c`. Repeating the event leaves the bit set, and no other event kind clears it.
- R4: Events on several ports in the same cycle are merged by XOR into one update. Two toggles of the same bit cancel, while toggles of different bits all take effect.
- R5: A port whose `ev_valid` bit is low has no effect, whatever its channel and kind inputs hold.
- R6: When `publish` is high and the live word differs from the published copy, the copy takes the live value that stood before that clock edge. Events in the same cycle are left for the next publish.
- R7: `irq_o` is high for exactly the one cycle after a `publish` in which (live XOR published) AND mask is non-zero. In every other cycle it is low.
- R8: If every bit that changed since the last publish has flipped back, a `publish` leaves the copy unchanged and raises no interrupt.
- R9: `pub_wr_en` loads `pub_wr_data` into the published copy. In a cycle with `publish` high, the software write is ignored.
- R10: `mask_wr_en` loads `mask_wr_data` into the interrupt mask. Only bits set in the mask can cause an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | PORTS | One valid bit per event port |
| ev_chan | input | PORTS*CHW | Channel index per port; port p uses bits p*CHW upward |
| ev_kind | input | PORTS*2 | Event kind per port: 0 done, 1 bad seal, 2 underrun, 3 bad wakeup |
| publish | input | 1 | End-of-pass pulse that compares and publishes the live word |
| pub_wr_en | input | 1 | Software write strobe for the published copy |
| pub_wr_data | input | W | Value for the published copy |
| mask_wr_en | input | 1 | Write strobe for the interrupt mask |
| mask_wr_data | input | W | Value for the interrupt mask |
| status_o | output | W | Live status word |
| published_o | output | W | Last published copy |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The properties assume that `publish` is a single-cycle strobe per pass and that the channel index of a valid event lies within the configured channel count. With a power-of-two count, every index is in range. They also assume reset is held across at least one rising edge before any stimulus. The stimulus changes every input on falling edges and holds it through the following rising edge. It issues `publish` only as isolated or back-to-back single-cycle strobes, and uses only indices 0 to 3 with the default four channels.

// File: rtl/tse_pkg.sv
package tse_pkg;

  typedef enum logic [1:0] {
    KIND_DONE     = 2'd0,
    KIND_SEAL     = 2'd1,
    KIND_UNDERRUN = 2'd2,
    KIND_BADWAKE  = 2'd3
  } ev_kind_e;

  localparam int KIND_W = 2;

endpackage

// File: rtl/tse_event_merge.sv
module tse_event_merge #(
  parameter int NUM_CH = 4,
  parameter int STRIDE = 3,
  parameter int PORTS  = 2,
  parameter int CHW    = 2,
  parameter int W      = 16
) (
  input  logic [PORTS-1:0]     ev_valid,
  input  logic [PORTS*CHW-1:0] ev_chan,
  input  logic [PORTS*2-1:0]   ev_kind,
  output logic [W-1:0]         flip_mask,
  output logic [W-1:0]         set_mask
);
  import tse_pkg::*;

  localparam int TOG_W = NUM_CH * STRIDE;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] port_flip [PORTS];
  logic [W-1:0] port_set  [PORTS];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [CHW-1:0] ch;
    ev_kind_e       kind;
    logic           is_wake;
    assign ch      = ev_chan[p*CHW +: CHW];
    assign kind    = ev_kind_e'(ev_kind[p*KIND_W +: KIND_W]);
    assign is_wake = (kind == KIND_BADWAKE);
    assign port_flip[p] = (ev_valid[p] && !is_wake)
                          ? (ONE << (STRIDE * int'(ch) + int'(kind))) : '0;
    assign port_set[p]  = (ev_valid[p] && is_wake)
                          ? (ONE << (TOG_W + int'(ch))) : '0;
  end

  always_comb begin
    flip_mask = '0;
    set_mask  = '0;
    for (int p = 0; p < PORTS; p++) begin
      flip_mask = flip_mask ^ port_flip[p];
      set_mask  = set_mask  | port_set[p];
    end
  end

endmodule

// File: rtl/tse_publish.sv
module tse_publish #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         publish_i,
  input  logic [W-1:0] live_i,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         mask_en,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] pub_o,
  output logic         irq_o
);

  logic [W-1:0] pub_q;
  logic [W-1:0] mask_q;
  logic         irq_q;
  logic [W-1:0] diff;

  assign diff = live_i ^ pub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pub_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (publish_i) begin
        if (diff != '0) pub_q <= live_i;
        irq_q <= |(diff & mask_q);
      end else if (wr_en) begin
        pub_q <= wr_data;
      end
      if (mask_en) mask_q <= mask_data;
    end
  end

  assign pub_o = pub_q;
  assign irq_o = irq_q;

  assert_pub_capture_R6: assert property (@(posedge clk) disable iff (rst)
    (publish_i && (live_i != pub_q)) |=> (pub_q == $past(live_i)));

  assert_irq_after_publish_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(publish_i));

  assert_irq_needs_change_R8: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (pub_q != $past(pub_q)));

endmodule

// File: rtl/tse_status.sv
module tse_status #(
  parameter int NUM_CH = 4,
  parameter int STRIDE = 3,
  parameter int PORTS  = 2,
  localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int TOG_W = NUM_CH * STRIDE,
  localparam int W     = TOG_W + NUM_CH
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PORTS-1:0]     ev_valid,
  input  logic [PORTS*CHW-1:0] ev_chan,
  input  logic [PORTS*2-1:0]   ev_kind,
  input  logic                 publish,
  input  logic                 pub_wr_en,
  input  logic [W-1:0]         pub_wr_data,
  input  logic                 mask_wr_en,
  input  logic [W-1:0]         mask_wr_data,
  output logic [W-1:0]         status_o,
  output logic [W-1:0]         published_o,
  output logic                 irq_o
);

  localparam logic [W-1:0] WAKE_FIELD = {{NUM_CH{1'b1}}, {TOG_W{1'b0}}};

  logic [W-1:0] flip_mask;
  logic [W-1:0] set_mask;
  logic [W-1:0] status_q;

  tse_event_merge #(
    .NUM_CH(NUM_CH), .STRIDE(STRIDE), .PORTS(PORTS), .CHW(CHW), .W(W)
  ) u_merge (
    .ev_valid  (ev_valid),
    .ev_chan   (ev_chan),
    .ev_kind   (ev_kind),
    .flip_mask (flip_mask),
    .set_mask  (set_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q ^ flip_mask) | set_mask;
  end

  assign status_o = status_q;

  tse_publish #(.W(W)) u_pub (
    .clk       (clk),
    .rst       (rst),
    .publish_i (publish),
    .live_i    (status_q),
    .wr_en     (pub_wr_en),
    .wr_data   (pub_wr_data),
    .mask_en   (mask_wr_en),
    .mask_data (mask_wr_data),
    .pub_o     (published_o),
    .irq_o     (irq_o)
  );

  assert_quiet_ports_R5: assert property (@(posedge clk) disable iff (rst)
    (ev_valid == '0) |=> $stable(status_q));

  assert_wake_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(status_q) & WAKE_FIELD)
              == ($past(status_q) & WAKE_FIELD)));

endmodule

// File: tb/tse_status_test.sv
`timescale 1ns/1ps
module tse_status_test;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ev_valid = '0;
  logic [3:0]    ev_chan = '0;
  logic [3:0]    ev_kind = '0;
  logic          publish = 1'b0;
  logic          pub_wr_en = 1'b0;
  logic [W-1:0]  pub_wr_data = '0;
  logic          mask_wr_en = 1'b0;
  logic [W-1:0]  mask_wr_data = '0;
  logic [W-1:0]  status_o;
  logic [W-1:0]  published_o;
  logic          irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tse_status uut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_chan(ev_chan),
    .ev_kind(ev_kind), .publish(publish), .pub_wr_en(pub_wr_en),
    .pub_wr_data(pub_wr_data), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .status_o(status_o),
    .published_o(published_o), .irq_o(irq_o)
  );

  // row: valid[2] ch0[2] k0[2] ch1[2] k1[2] publish[1] exp_status[16] exp_pub[16] exp_irq[1]
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {2'b01, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h0001, 16'h0000, 1'b0}, // R2
    {2'b01, 2'd1, 2'd1, 2'd0, 2'd0, 1'b0, 16'h0011, 16'h0000, 1'b0}, // R2
    {2'b00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 16'h0011, 16'h0011, 1'b1}, // R6 R7
    {2'b00, 2'd3, 2'd0, 2'd2, 2'd1, 1'b0, 16'h0011, 16'h0011, 1'b0}, // R5
    {2'b11, 2'd2, 2'd2, 2'd2, 2'd2, 1'b0, 16'h0011, 16'h0011, 1'b0}, // R4 cancel
    {2'b11, 2'd3, 2'd0, 2'd3, 2'd3, 1'b0, 16'h8211, 16'h0011, 1'b0}, // R4 R3
    {2'b01, 2'd3, 2'd3, 2'd0, 2'd0, 1'b1, 16'h8211, 16'h8211, 1'b1}, // R3 R6
    {2'b01, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h8210, 16'h8211, 1'b0}, // R2
    {2'b01, 2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 16'h8211, 16'h8211, 1'b0}, // R8 setup
    {2'b00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 16'h8211, 16'h8211, 1'b0}, // R8
    {2'b11, 2'd0, 2'd2, 2'd2, 2'd1, 1'b1, 16'h8295, 16'h8211, 1'b0}, // R6 pre-edge
    {2'b00, 2'd0, 2'd0, 2'd0, 2'd0, 1'b1, 16'h8295, 16'h8295, 1'b1}  // R6 R7
  };

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_valid = '0; publish = 1'b0; pub_wr_en = 1'b0; mask_wr_en = 1'b0;
  endtask

  task automatic do_event(input logic [1:0] ch, input logic [1:0] kind, input bit pub);
    ev_valid = 2'b01; ev_chan = {2'd0, ch}; ev_kind = {2'd0, kind}; publish = pub;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_publish();
    publish = 1'b1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check_all(input string req, input logic [W-1:0] s,
                           input logic [W-1:0] p, input logic i);
    check(status_o == s, req, status_o, s);
    check(published_o == p, req, published_o, p);
    check(irq_o == i, req, W'(irq_o), W'(i));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset", 16'h0000, 16'h0000, 1'b0);

    mask_wr_en = 1'b1; mask_wr_data = 16'hFFFF;
    @(negedge clk);
    idle_inputs();

    for (int i = 0; i < NV; i++) begin
      ev_valid = VEC[i][43:42];
      ev_chan  = {VEC[i][37:36], VEC[i][41:40]};
      ev_kind  = {VEC[i][35:34], VEC[i][39:38]};
      publish  = VEC[i][33];
      @(negedge clk);
      check_all($sformatf("R2-table row %0d", i), VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
    end
    idle_inputs();
    @(negedge clk);
    check(irq_o == 1'b0, "R7 one-cycle pulse", W'(irq_o), 16'h0);

    // R10: mask only bit 2
    mask_wr_en = 1'b1; mask_wr_data = 16'h0004;
    @(negedge clk);
    idle_inputs();
    do_event(2'd0, 2'd0, 1'b0);             // bit0 -> 8294
    do_publish();
    check_all("R10 masked-off change", 16'h8294, 16'h8294, 1'b0);
    do_event(2'd0, 2'd2, 1'b0);             // bit2 -> 8290
    do_publish();
    check_all("R10 enabled change", 16'h8290, 16'h8290, 1'b1);

    // R9: software write, then write colliding with publish
    pub_wr_en = 1'b1; pub_wr_data = 16'h1234;
    @(negedge clk);
    idle_inputs();
    check_all("R9 software write", 16'h8290, 16'h1234, 1'b0);
    pub_wr_en = 1'b1; pub_wr_data = 16'h0000; publish = 1'b1;
    @(negedge clk);
    idle_inputs();
    check_all("R9 publish wins", 16'h8290, 16'h8290, 1'b1);

    // R3: bad wakeup bit survives repeat and toggles on same channel
    do_event(2'd1, 2'd3, 1'b0);             // bit13 -> a290
    do_event(2'd1, 2'd3, 1'b0);
    check(status_o == 16'hA290, "R3 repeat stays set", status_o, 16'hA290);

    // R1: reset mid-run clears everything, including the mask
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 mid-run reset", 16'h0000, 16'h0000, 1'b0);
    do_event(2'd0, 2'd2, 1'b0);
    do_publish();
    check_all("R1 mask cleared", 16'h0004, 16'h0004, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule